// File: doc/BRIEF.md
# 64-bit Integer ALU with Condition Flags

This block is the integer execution unit of a small load/store processor. It receives two 64-bit operands, the top eleven bits of the instruction word as an opcode, the 12-bit immediate field and the 6-bit shift field. From these it forms a 64-bit result in the same cycle. The operation is chosen directly from the raw opcode bits, with no separate ALU control code. The register form uses all eleven bits. The immediate form uses only the upper ten.

A four-bit condition register holds negative, zero, overflow and carry. It is written only at a clock edge, and only when a valid operation is one of the flag-setting variants. The surrounding pipeline can therefore interleave ordinary arithmetic between a compare and the branch that consumes its flags. A compare is a flag-setting subtract aimed at register 31. In that case the flags update, but the result write-enable stays low.

Top module: `alu_flags_unit`

## Requirements
- R1: Register-form logic opcodes give the bitwise result of `opa` and `opb`: 0x450 AND, 0x550 OR, 0x650 XOR, and 0x750 AND with flag update.
- R2: Register-form arithmetic opcodes give the result modulo 2^64: 0x458 `opa+opb`, 0x658 `opa-opb`, 0x558 add with flag update, and 0x758 subtract with flag update.
- R3: When the register-form table has no match, `op_code[10:1]` selects an immediate form: 0x244 add, 0x344 subtract, 0x248 AND, 0x168 OR, 0x348 XOR, 0x164 add with flags, 0x2C4 subtract with flags, 0x2C8 AND with flags. In these forms `imm12`, zero-extended to 64 bits, replaces `opb`, and `op_code[0]` is ignored.
- R4: Opcode 0x69A shifts `opa` right and 0x69B shifts it left, by `shamt` (0 to 63), filling with zeros.
- R5: `flags` is {N,Z,V,C}, with N in bit 3 and C in bit 0. It changes only at a rising clock edge where `op_valid` is high and the opcode is one of the six flag-setting opcodes. Every other cycle leaves it unchanged.
- R6: On a flag update, N takes result bit 63 and Z is set exactly when the result is zero.
- R7: For flag-setting adds, C is the carry out of bit 63 and V is set when two operands of equal sign give a result of the other sign.
- R8: For flag-setting subtracts, C is set when no borrow occurs (`opa >= operand B` unsigned), and V is the signed overflow of `opa - operand B`.
- R9: Flag-setting AND operations (register or immediate) clear V and C.
- R10: `res_wr_en` is high only when `op_valid` is high, the opcode is recognised, and `rd_idx` is not 31. A subtract with flags aimed at register 31 updates the flags but does not write.
- R11: An unrecognised opcode gives a result of zero, keeps `res_wr_en` low and leaves the flags unchanged.
- R12: An active-low `rst_n` clears the flags to 0000 at once, whatever the clock is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 11 | Instruction bits 31:21 |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand for register forms |
| imm12 | input | 12 | Immediate field, zero-extended |
| shamt | input | 6 | Shift amount |
| rd_idx | input | 5 | Destination register index |
| result | output | 64 | Combinational result |
| res_wr_en | output | 1 | Result should be written back |
| flags | output | 4 | Condition register {N,Z,V,C} |

## Verification
The hardest situation to reach from the ports is a flag register that visibly holds its value. A hold can only be seen if the flags were driven to a distinctive non-zero pattern just beforehand. The stimulus is therefore a chained sequence in which each flag-setting step leaves a pattern different from the one the next step would produce. Non-flag operations, an invalid cycle and an unknown opcode are then slotted between those steps. Overflow cases sit at the signed boundary (0x7FFF... + 1 and 0x8000... - 1), so that V and C are exercised in every combination that add and subtract can reach.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [2:0] {
    K_ADD,
    K_SUB,
    K_AND,
    K_ORR,
    K_EOR,
    K_LSR,
    K_LSL,
    K_NONE
  } alu_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

  // register-form opcodes, all eleven bits
  localparam logic [10:0] RF_AND  = 11'h450;
  localparam logic [10:0] RF_ADD  = 11'h458;
  localparam logic [10:0] RF_ORR  = 11'h550;
  localparam logic [10:0] RF_ADDS = 11'h558;
  localparam logic [10:0] RF_EOR  = 11'h650;
  localparam logic [10:0] RF_SUB  = 11'h658;
  localparam logic [10:0] RF_LSR  = 11'h69A;
  localparam logic [10:0] RF_LSL  = 11'h69B;
  localparam logic [10:0] RF_ANDS = 11'h750;
  localparam logic [10:0] RF_SUBS = 11'h758;

  // immediate-form opcodes, upper ten bits
  localparam logic [9:0] IF_ADD  = 10'h244;
  localparam logic [9:0] IF_AND  = 10'h248;
  localparam logic [9:0] IF_ADDS = 10'h164;
  localparam logic [9:0] IF_ORR  = 10'h168;
  localparam logic [9:0] IF_SUB  = 10'h344;
  localparam logic [9:0] IF_EOR  = 10'h348;
  localparam logic [9:0] IF_SUBS = 10'h2C4;
  localparam logic [9:0] IF_ANDS = 10'h2C8;

endpackage

// File: rtl/alu_opc_decode.sv
module alu_opc_decode
  import alu_flags_pkg::*;
#(
  parameter int OPC_W = 11
) (
  input  logic [OPC_W-1:0] op_code,
  output alu_kind_e        kind,
  output logic             use_imm,
  output logic             set_flags,
  output logic             known
);

  alu_kind_e rf_kind;
  logic      rf_flags;
  logic      rf_hit;
  alu_kind_e if_kind;
  logic      if_flags;
  logic      if_hit;

  always_comb begin
    rf_kind  = K_NONE;
    rf_flags = 1'b0;
    rf_hit   = 1'b1;
    case (op_code)
      RF_AND:  rf_kind = K_AND;
      RF_ADD:  rf_kind = K_ADD;
      RF_ORR:  rf_kind = K_ORR;
      RF_ADDS: begin rf_kind = K_ADD; rf_flags = 1'b1; end
      RF_EOR:  rf_kind = K_EOR;
      RF_SUB:  rf_kind = K_SUB;
      RF_LSR:  rf_kind = K_LSR;
      RF_LSL:  rf_kind = K_LSL;
      RF_ANDS: begin rf_kind = K_AND; rf_flags = 1'b1; end
      RF_SUBS: begin rf_kind = K_SUB; rf_flags = 1'b1; end
      default: rf_hit = 1'b0;
    endcase
  end

  always_comb begin
    if_kind  = K_NONE;
    if_flags = 1'b0;
    if_hit   = 1'b1;
    case (op_code[OPC_W-1:1])
      IF_ADD:  if_kind = K_ADD;
      IF_AND:  if_kind = K_AND;
      IF_ADDS: begin if_kind = K_ADD; if_flags = 1'b1; end
      IF_ORR:  if_kind = K_ORR;
      IF_SUB:  if_kind = K_SUB;
      IF_EOR:  if_kind = K_EOR;
      IF_SUBS: begin if_kind = K_SUB; if_flags = 1'b1; end
      IF_ANDS: begin if_kind = K_AND; if_flags = 1'b1; end
      default: if_hit = 1'b0;
    endcase
  end

  // register form has priority; the two tables do not overlap
  always_comb begin
    if (rf_hit) begin
      kind      = rf_kind;
      use_imm   = 1'b0;
      set_flags = rf_flags;
    end else if (if_hit) begin
      kind      = if_kind;
      use_imm   = 1'b1;
      set_flags = if_flags;
    end else begin
      kind      = K_NONE;
      use_imm   = 1'b0;
      set_flags = 1'b0;
    end
    known = rf_hit | if_hit;
  end

endmodule

// File: rtl/alu_exec_core.sv
module alu_exec_core
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 12,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  alu_kind_e         kind,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] res,
  output nzvc_t             arith_flags
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] b_src;
  logic [DATA_W-1:0] b_eff;
  logic              is_sub;
  logic [DATA_W:0]   sum_w;
  logic              is_logic;

  assign b_src  = use_imm ? {{PAD_W{1'b0}}, imm} : opb;
  assign is_sub = (kind == K_SUB);
  assign b_eff  = is_sub ? ~b_src : b_src;
  assign sum_w  = {1'b0, opa} + {1'b0, b_eff} + {{DATA_W{1'b0}}, is_sub};

  always_comb begin
    case (kind)
      K_ADD, K_SUB: res = sum_w[DATA_W-1:0];
      K_AND:        res = opa & b_src;
      K_ORR:        res = opa | b_src;
      K_EOR:        res = opa ^ b_src;
      K_LSR:        res = opa >> shamt;
      K_LSL:        res = opa << shamt;
      default:      res = '0;
    endcase
  end

  assign is_logic = (kind == K_AND);

  always_comb begin
    arith_flags.n = res[DATA_W-1];
    arith_flags.z = (res == '0);
    if (is_logic) begin
      arith_flags.v = 1'b0;
      arith_flags.c = 1'b0;
    end else begin
      arith_flags.v = (opa[DATA_W-1] == b_eff[DATA_W-1]) &&
                      (sum_w[DATA_W-1] != opa[DATA_W-1]);
      arith_flags.c = sum_w[DATA_W];
    end
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flags_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flag_we,
  input  nzvc_t flag_d,
  output nzvc_t flag_q
);

  nzvc_t flag_nxt;

  always_comb begin
    flag_nxt = flag_q;
    if (flag_we) begin
      flag_nxt = flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_nxt;
    end
  end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int IMM_W     = 12,
  parameter int OPC_W     = 11,
  parameter int REG_IDX_W = 5,
  parameter int SH_W      = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [OPC_W-1:0]     op_code,
  input  logic [DATA_W-1:0]    opa,
  input  logic [DATA_W-1:0]    opb,
  input  logic [IMM_W-1:0]     imm12,
  input  logic [SH_W-1:0]      shamt,
  input  logic [REG_IDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0]    result,
  output logic                 res_wr_en,
  output logic [3:0]           flags
);

  localparam logic [REG_IDX_W-1:0] ZR_IDX = {REG_IDX_W{1'b1}};

  alu_kind_e kind;
  logic      use_imm;
  logic      set_flags;
  logic      known;
  nzvc_t     core_flags;
  nzvc_t     flag_q;
  logic      flag_we;

  alu_opc_decode #(.OPC_W(OPC_W)) dec_i (
    .op_code  (op_code),
    .kind     (kind),
    .use_imm  (use_imm),
    .set_flags(set_flags),
    .known    (known)
  );

  alu_exec_core #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) core_i (
    .kind       (kind),
    .use_imm    (use_imm),
    .opa        (opa),
    .opb        (opb),
    .imm        (imm12),
    .shamt      (shamt),
    .res        (result),
    .arith_flags(core_flags)
  );

  assign flag_we = op_valid & set_flags;

  alu_flag_reg flg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag_we(flag_we),
    .flag_d (core_flags),
    .flag_q (flag_q)
  );

  assign flags     = flag_q;
  assign res_wr_en = op_valid & known & (rd_idx != ZR_IDX);

  AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags)); // R5

  AST_SIGN_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flags[3] == $past(result[DATA_W-1])) &&
                (flags[2] == ($past(result) == '0))); // R6

  AST_LOGIC_CLEARS_VC: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && kind == K_AND) |=> (flags[1:0] == 2'b00)); // R9

  AST_NO_ZR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == ZR_IDX) |-> !res_wr_en); // R10

  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> (result == '0) && !res_wr_en); // R11

endmodule

// File: tb/alu_flags_unit_tb.sv
module alu_flags_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [10:0] op_code;
  logic [63:0] opa;
  logic [63:0] opb;
  logic [11:0] imm12;
  logic [5:0]  shamt;
  logic [4:0]  rd_idx;
  logic [63:0] result;
  logic        res_wr_en;
  logic [3:0]  flags;

  int checks;
  int fails;

  alu_flags_unit dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .opa      (opa),
    .opb      (opb),
    .imm12    (imm12),
    .shamt    (shamt),
    .rd_idx   (rd_idx),
    .result   (result),
    .res_wr_en(res_wr_en),
    .flags    (flags)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // op(11) a(64) b(64) imm(12) sh(6) expected(64)
  localparam int NV = 15;
  localparam logic [220:0] VEC [NV] = '{
    {11'h450, 64'hF0F0F0F0F0F0F0F0, 64'hFF00FF00FF00FF00, 12'h0, 6'd0, 64'hF000F000F000F000}, // R1
    {11'h550, 64'hF0F0F0F0F0F0F0F0, 64'hFF00FF00FF00FF00, 12'h0, 6'd0, 64'hFFF0FFF0FFF0FFF0}, // R1
    {11'h650, 64'hF0F0F0F0F0F0F0F0, 64'hFF00FF00FF00FF00, 12'h0, 6'd0, 64'h0FF00FF00FF00FF0}, // R1
    {11'h750, 64'h00000000FFFF0000, 64'h0000FFFFFFFF0000, 12'h0, 6'd0, 64'h00000000FFFF0000}, // R1
    {11'h458, 64'h7FFFFFFFFFFFFFFF, 64'h0000000000000001, 12'h0, 6'd0, 64'h8000000000000000}, // R2
    {11'h658, 64'h0000000000000005, 64'h0000000000000007, 12'h0, 6'd0, 64'hFFFFFFFFFFFFFFFE}, // R2
    {11'h69A, 64'h8000000000000001, 64'h0, 12'h0, 6'd63, 64'h0000000000000001},               // R4
    {11'h69B, 64'h0123456789ABCDEF, 64'h0, 12'h0, 6'd4,  64'h123456789ABCDEF0},               // R4
    {11'h69B, 64'h0000000000000055, 64'h0, 12'h0, 6'd0,  64'h0000000000000055},               // R4
    {11'h489, 64'd100, 64'hFFFFFFFFFFFFFFFF, 12'hFFF, 6'd0, 64'h0000000000001063},            // R3
    {11'h688, 64'h1000, 64'h0, 12'h001, 6'd0, 64'h0000000000000FFF},                          // R3
    {11'h490, 64'hFFFFFFFFFFFFFFFF, 64'h0, 12'hABC, 6'd0, 64'h0000000000000ABC},              // R3
    {11'h2D0, 64'hF000000000000000, 64'h0, 12'h00F, 6'd0, 64'hF00000000000000F},              // R3
    {11'h690, 64'h0000000000000FFF, 64'h0, 12'h0F0, 6'd0, 64'h0000000000000F0F},              // R3
    {11'h000, 64'h1234, 64'h5678, 12'h0, 6'd0, 64'h0}                                         // R11
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply at negedge, check result mid-cycle, clock it, check flags at next negedge
  task automatic flag_op(input string req, input logic v, input logic [10:0] oc,
                         input logic [63:0] a, input logic [63:0] b, input logic [11:0] im,
                         input logic [4:0] rd, input logic [63:0] exp_res,
                         input logic exp_we, input logic [3:0] exp_fl);
    op_valid = v; op_code = oc; opa = a; opb = b; imm12 = im; shamt = 6'd0; rd_idx = rd;
    #1;
    chk(req, result, exp_res);
    chk(req, {63'd0, res_wr_en}, {63'd0, exp_we});
    @(negedge clk);
    chk(req, {60'd0, flags}, {60'd0, exp_fl});
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; opa = '0; opb = '0;
    imm12 = '0; shamt = '0; rd_idx = 5'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R12 reset", {60'd0, flags}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      op_valid = 1'b0;
      op_code  = VEC[i][220:210];
      opa      = VEC[i][209:146];
      opb      = VEC[i][145:82];
      imm12    = VEC[i][81:70];
      shamt    = VEC[i][69:64];
      rd_idx   = 5'd1;
      #1;
      chk($sformatf("R1-4 vec%0d result", i), result, VEC[i][63:0]);
      op_valid = 1'b1;
      #1;
      chk($sformatf("R10 vec%0d wr_en", i), {63'd0, res_wr_en},
          {63'd0, (VEC[i][220:210] != 11'h000)});
      @(negedge clk);
    end
    op_valid = 1'b0;
    @(negedge clk);
    // table ran non-flag ops plus one ANDS (0x750) with nonzero result
    chk("R9 table-end flags", {60'd0, flags}, 64'd0);

    flag_op("R7 adds overflow",  1, 11'h558, 64'h7FFFFFFFFFFFFFFF, 64'd1, 12'h0, 5'd2,
            64'h8000000000000000, 1, 4'b1010);
    flag_op("R7 adds carry",     1, 11'h558, 64'hFFFFFFFFFFFFFFFF, 64'd1, 12'h0, 5'd2,
            64'h0, 1, 4'b0101);
    flag_op("R5 add holds",      1, 11'h458, 64'hFFFFFFFFFFFFFFFF, 64'd1, 12'h0, 5'd2,
            64'h0, 1, 4'b0101);
    flag_op("R10 compare borrow", 1, 11'h758, 64'd3, 64'd5, 12'h0, 5'd31,
            64'hFFFFFFFFFFFFFFFE, 0, 4'b1000);
    flag_op("R8 subs equal",     1, 11'h758, 64'd5, 64'd5, 12'h0, 5'd3,
            64'h0, 1, 4'b0101);
    flag_op("R8 subs overflow",  1, 11'h758, 64'h8000000000000000, 64'd1, 12'h0, 5'd3,
            64'h7FFFFFFFFFFFFFFF, 1, 4'b0011);
    flag_op("R9 ands clears vc", 1, 11'h750, 64'h8000000000000000, 64'h8000000000000000,
            12'h0, 5'd3, 64'h8000000000000000, 1, 4'b1000);
    flag_op("R8 subis equal",    1, 11'h588, 64'd10, 64'hFFFF, 12'd10, 5'd4,
            64'h0, 1, 4'b0101);
    flag_op("R7 addis carry",    1, 11'h2C8, 64'hFFFFFFFFFFFFFFFF, 64'h0, 12'd2, 5'd4,
            64'h1, 1, 4'b0001);
    flag_op("R9 andis zero",     1, 11'h590, 64'h0F, 64'hFF, 12'hF0, 5'd4,
            64'h0, 1, 4'b0100);
    flag_op("R5 invalid holds",  0, 11'h758, 64'd0, 64'd1, 12'h0, 5'd4,
            64'hFFFFFFFFFFFFFFFF, 0, 4'b0100);
    flag_op("R11 unknown opcode", 1, 11'h7FF, 64'd9, 64'd9, 12'h0, 5'd4,
            64'h0, 0, 4'b0100);

    op_valid = 1'b0;
    #2;
    rst_n = 1'b0;
    #1;
    chk("R12 async reset", {60'd0, flags}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 stays clear", {60'd0, flags}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule